// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block computes the effective address for a 32-bit two-operand processor. Each cycle the issue logic may present one request that carries a base register value, an index register value, a two-bit scale code, an addressing form, a displacement and a destination register number. The block adds the selected terms and registers the result, so the answer appears one clock after the request.

A per-request flag selects where the answer goes. In address-return mode the sum is delivered as data on a register write port, together with the destination number, and no memory access is started. In memory mode the sum is driven on a memory request port instead. Addresses carry no alignment restriction. Each output port keeps its last value until a request for that port replaces it.

Top module: `eff_addr_unit`

## Requirements
- R1: With `reqForm` = 0 the address is `reqBase` plus the sign-extended displacement. The index and scale are ignored.
- R2: With `reqForm` = 1 the address is `reqBase + reqIndex`. The displacement and scale are ignored.
- R3: With `reqForm` = 2 the address is `reqBase + (reqIndex << reqScale)`, where `reqScale` values 0 to 3 multiply the index by 1, 2, 4 or 8. The displacement is ignored.
- R4: With `reqForm` = 3 the address is `reqBase + (reqIndex << reqScale)` plus the displacement.
- R5: When `reqDispWide` = 0 only `reqDisp[7:0]` is used, sign-extended to 32 bits, and bits 31:8 have no effect. When `reqDispWide` = 1 all 32 bits of `reqDisp` are used.
- R6: All sums wrap modulo 2^32 and no overflow indication exists.
- R7: A valid request with `reqRetAddr` = 1 gives `wbValid` = 1, `wbData` = address and `wbDest` = `reqDest` on the next cycle. In that cycle `memValid` = 0 and `memAddr` keeps its previous value.
- R8: A valid request with `reqRetAddr` = 0 gives `memValid` = 1 and `memAddr` = address on the next cycle. In that cycle `wbValid` = 0 and `wbData` and `wbDest` keep their previous values.
- R9: A cycle with `reqValid` = 0 gives `wbValid` = 0 and `memValid` = 0 on the next cycle, and every data output holds its value.
- R10: While `rstN` is low at a clock edge, `wbValid`, `memValid`, `wbData`, `wbDest` and `memAddr` are all cleared to 0 after that edge, whatever the request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqForm | input | 2 | Addressing form: 0 base+disp, 1 base+index, 2 base+scaled index, 3 base+scaled index+disp |
| reqScale | input | 2 | Left shift applied to the index (0 to 3) |
| reqRetAddr | input | 1 | 1 = return the address on the write port; 0 = issue a memory request |
| reqDispWide | input | 1 | 1 = 32-bit displacement; 0 = sign-extended 8-bit displacement |
| reqBase | input | 32 | Base register value |
| reqIndex | input | 32 | Index register value |
| reqDisp | input | 32 | Displacement immediate |
| reqDest | input | 3 | Destination register number for address-return mode |
| wbValid | output | 1 | Register write strobe |
| wbDest | output | 3 | Register write destination |
| wbData | output | 32 | Address returned as data |
| memValid | output | 1 | Memory request strobe |
| memAddr | output | 32 | Memory request address |

## Verification
An address-return result and a memory request can both be present in the same cycle. In that cycle one port shows its new result while the other still shows an older one. The bench provokes this with back-to-back requests of opposite kinds, with no idle cycle between them, and then with a run of idle cycles. After each edge it compares all five outputs with a bench model. That model changes only the port the request selected, so a write strobe that leaks onto the wrong port is caught, and so is a data value that the other port overwrote.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [1:0] {
    FORM_BASE_DISP   = 2'd0,
    FORM_BASE_INDEX  = 2'd1,
    FORM_SCALED      = 2'd2,
    FORM_SCALED_DISP = 2'd3
  } formE;

  // strobes from decode to the datapath
  typedef struct packed {
    logic useIndex;
    logic useScale;
    logic useDisp;
    logic dispWide;
    logic toWb;
    logic toMem;
  } strobeT;

endpackage

// File: rtl/eau_ctrl.sv
module eau_ctrl
  import eau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqForm,
  input  logic       reqRetAddr,
  input  logic       reqDispWide,
  output strobeT     strb
);

  formE form;
  assign form = formE'(reqForm);

  always_comb begin
    strb          = '0;
    strb.useIndex = (form != FORM_BASE_DISP);
    strb.useScale = (form == FORM_SCALED) || (form == FORM_SCALED_DISP);
    strb.useDisp  = (form == FORM_BASE_DISP) || (form == FORM_SCALED_DISP);
    strb.dispWide = reqDispWide;
    strb.toWb     = reqValid && reqRetAddr;
    strb.toMem    = reqValid && !reqRetAddr;
  end

  // R7 R8: a request never targets both ports
  a_r8_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.toWb, strb.toMem}));

  // R9: no strobe without a request
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(strb.toWb || strb.toMem));

endmodule

// File: rtl/eau_dpath.sv
module eau_dpath
  import eau_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DISP_SHORT  = 8,
  parameter int SCALE_W     = 2,
  parameter int DEST_W      = 3
)(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [ADDR_W-1:0]  reqBase,
  input  logic [ADDR_W-1:0]  reqIndex,
  input  logic [ADDR_W-1:0]  reqDisp,
  input  logic [SCALE_W-1:0] reqScale,
  input  logic [DEST_W-1:0]  reqDest,
  output logic               wbValid,
  output logic [DEST_W-1:0]  wbDest,
  output logic [ADDR_W-1:0]  wbData,
  output logic               memValid,
  output logic [ADDR_W-1:0]  memAddr
);

  localparam int NUM_SCALES = 1 << SCALE_W;
  localparam int EXT_W      = ADDR_W - DISP_SHORT;

  logic [ADDR_W-1:0] shiftOpt [NUM_SCALES];
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] idxTerm;
  logic [ADDR_W-1:0] dispTerm;
  logic [ADDR_W-1:0] effAddr;

  // one pre-shifted copy of the index per scale code
  for (genvar s = 0; s < NUM_SCALES; s++) begin : g_shift
    assign shiftOpt[s] = reqIndex << s;
  end

  always_comb begin
    dispExt  = strb.dispWide ? reqDisp
             : {{EXT_W{reqDisp[DISP_SHORT-1]}}, reqDisp[DISP_SHORT-1:0]};
    idxTerm  = strb.useIndex ? (strb.useScale ? shiftOpt[reqScale] : reqIndex)
             : '0;
    dispTerm = strb.useDisp ? dispExt : '0;
    effAddr  = reqBase + idxTerm + dispTerm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid  <= 1'b0;
      memValid <= 1'b0;
      wbDest   <= '0;
      wbData   <= '0;
      memAddr  <= '0;
    end else begin
      wbValid  <= strb.toWb;
      memValid <= strb.toMem;
      if (strb.toWb) begin
        wbData <= effAddr;
        wbDest <= reqDest;
      end
      if (strb.toMem) begin
        memAddr <= effAddr;
      end
    end
  end

  // R7: an address-return request lands only on the write port
  a_r7_wb_only: assert property (@(posedge clk) disable iff (!rstN)
    strb.toWb |=> wbValid && !memValid && $stable(memAddr));

  // R8: a memory request lands only on the memory port
  a_r8_mem_only: assert property (@(posedge clk) disable iff (!rstN)
    strb.toMem |=> memValid && !wbValid && $stable(wbData) && $stable(wbDest));

  // R9: idle cycles hold every data output
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.toWb || strb.toMem) |=> !wbValid && !memValid
      && $stable(wbData) && $stable(memAddr) && $stable(wbDest));

  // R10: reset clears all outputs
  a_r10_reset_clear: assert property (@(posedge clk)
    !rstN |=> !wbValid && !memValid && wbData == '0 && memAddr == '0 && wbDest == '0);

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DISP_SHORT = 8,
  parameter int SCALE_W    = 2,
  parameter int DEST_W     = 3
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqForm,
  input  logic [SCALE_W-1:0] reqScale,
  input  logic               reqRetAddr,
  input  logic               reqDispWide,
  input  logic [ADDR_W-1:0]  reqBase,
  input  logic [ADDR_W-1:0]  reqIndex,
  input  logic [ADDR_W-1:0]  reqDisp,
  input  logic [DEST_W-1:0]  reqDest,
  output logic               wbValid,
  output logic [DEST_W-1:0]  wbDest,
  output logic [ADDR_W-1:0]  wbData,
  output logic               memValid,
  output logic [ADDR_W-1:0]  memAddr
);

  strobeT strb;

  eau_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqForm     (reqForm),
    .reqRetAddr  (reqRetAddr),
    .reqDispWide (reqDispWide),
    .strb        (strb)
  );

  eau_dpath #(
    .ADDR_W     (ADDR_W),
    .DISP_SHORT (DISP_SHORT),
    .SCALE_W    (SCALE_W),
    .DEST_W     (DEST_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqBase  (reqBase),
    .reqIndex (reqIndex),
    .reqDisp  (reqDisp),
    .reqScale (reqScale),
    .reqDest  (reqDest),
    .wbValid  (wbValid),
    .wbDest   (wbDest),
    .wbData   (wbData),
    .memValid (memValid),
    .memAddr  (memAddr)
  );

endmodule

// File: tb/eff_addr_unit_tb.sv
module eff_addr_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqForm = '0;
  logic [1:0]  reqScale = '0;
  logic        reqRetAddr = 1'b0;
  logic        reqDispWide = 1'b0;
  logic [31:0] reqBase = '0;
  logic [31:0] reqIndex = '0;
  logic [31:0] reqDisp = '0;
  logic [2:0]  reqDest = '0;
  logic        wbValid;
  logic [2:0]  wbDest;
  logic [31:0] wbData;
  logic        memValid;
  logic [31:0] memAddr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // bench model of the outputs expected after the next edge
  logic        mWbValid = 1'b0;
  logic        mMemValid = 1'b0;
  logic [2:0]  mWbDest = '0;
  logic [31:0] mWbData = '0;
  logic [31:0] mMemAddr = '0;

  eff_addr_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqForm(reqForm),
    .reqScale(reqScale), .reqRetAddr(reqRetAddr), .reqDispWide(reqDispWide),
    .reqBase(reqBase), .reqIndex(reqIndex), .reqDisp(reqDisp), .reqDest(reqDest),
    .wbValid(wbValid), .wbDest(wbDest), .wbData(wbData),
    .memValid(memValid), .memAddr(memAddr)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refAddr(input logic [1:0] f, input logic [1:0] sc,
      input logic wide, input logic [31:0] b, input logic [31:0] ix, input logic [31:0] d);
    logic [31:0] dx;
    logic [31:0] r;
    dx = wide ? d : {{24{d[7]}}, d[7:0]};
    case (f)
      2'd0:    r = b + dx;
      2'd1:    r = b + ix;
      2'd2:    r = b + ix * (32'd1 << sc);
      default: r = b + ix * (32'd1 << sc) + dx;
    endcase
    return r;
  endfunction

  // call at a negedge; outputs change at the following posedge
  task automatic issue(input logic [1:0] f, input logic [1:0] sc, input logic ret,
      input logic wide, input logic [31:0] b, input logic [31:0] ix,
      input logic [31:0] d, input logic [2:0] dst);
    reqValid = 1'b1; reqForm = f; reqScale = sc; reqRetAddr = ret;
    reqDispWide = wide; reqBase = b; reqIndex = ix; reqDisp = d; reqDest = dst;
    mWbValid  = ret;
    mMemValid = !ret;
    if (ret) begin
      mWbData = refAddr(f, sc, wide, b, ix, d);
      mWbDest = dst;
    end else begin
      mMemAddr = refAddr(f, sc, wide, b, ix, d);
    end
  endtask

  task automatic idle(input logic [31:0] junk);
    reqValid = 1'b0; reqBase = junk; reqIndex = ~junk; reqDisp = junk;
    reqRetAddr = junk[0]; reqForm = junk[2:1]; reqDest = junk[5:3];
    mWbValid = 1'b0; mMemValid = 1'b0;
  endtask

  task automatic checkOut(input string tag);
    chk({tag, " wbValid"},  {31'd0, wbValid},  {31'd0, mWbValid});
    chk({tag, " memValid"}, {31'd0, memValid}, {31'd0, mMemValid});
    chk({tag, " wbData"},   wbData,   mWbData);
    chk({tag, " wbDest"},   {29'd0, wbDest},   {29'd0, mWbDest});
    chk({tag, " memAddr"},  memAddr,  mMemAddr);
  endtask

  // one request, checked after its edge, then idle
  task automatic single(input string tag, input logic [1:0] f, input logic [1:0] sc,
      input logic ret, input logic wide, input logic [31:0] b, input logic [31:0] ix,
      input logic [31:0] d, input logic [2:0] dst);
    @(negedge clk);
    issue(f, sc, ret, wide, b, ix, d, dst);
    @(negedge clk);
    checkOut(tag);
    idle(32'h0);
  endtask

  task automatic testReset();
    // R10: request inputs active during reset must not reach the outputs
    @(negedge clk);
    reqValid = 1'b1; reqRetAddr = 1'b1; reqBase = 32'h1234; reqDest = 3'd6;
    repeat (2) @(negedge clk);
    checkOut("R10 reset");
    reqValid = 1'b0;
    rstN = 1'b1;
  endtask

  task automatic testForms();
    single("R1 R5 base+short disp", 2'd0, 2'd3, 1'b0, 1'b0, 32'h1000, 32'hDEAD, 32'hABCD12F0, 3'd0);
    chk("R5 short disp value", mMemAddr, 32'h0000_0FF0);
    single("R5 wide disp", 2'd0, 2'd0, 1'b0, 1'b1, 32'h1000, 32'h0, 32'h0001_2345, 3'd0);
    chk("R5 wide disp value", mMemAddr, 32'h0001_3345);
    single("R2 base+index", 2'd1, 2'd3, 1'b0, 1'b0, 32'h2000, 32'h34, 32'h55, 3'd0);
    chk("R2 value", mMemAddr, 32'h2034);
    for (int s = 0; s < 4; s++) begin
      single("R3 scaled index", 2'd2, 2'(s), 1'b0, 1'b0, 32'h100, 32'h11, 32'h7F, 3'd0);
      chk("R3 scale value", mMemAddr, 32'h100 + (32'h11 << s));
    end
    single("R4 scaled+disp", 2'd3, 2'd2, 1'b0, 1'b0, 32'h8000_0000, 32'h10, 32'h80, 3'd0);
    chk("R4 value", mMemAddr, 32'h7FFF_FFC0);
  endtask

  task automatic testWrap();
    single("R6 wrap", 2'd3, 2'd1, 1'b0, 1'b0, 32'hFFFF_FFF0, 32'h8, 32'h04, 3'd0);
    chk("R6 wrapped value", mMemAddr, 32'h0000_0004);
  endtask

  task automatic testRetAddr();
    single("R7 address return", 2'd3, 2'd3, 1'b1, 1'b1, 32'h4000, 32'h3, 32'h100, 3'd5);
    chk("R7 value", mWbData, 32'h4118);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    issue(2'd1, 2'd0, 1'b1, 1'b0, 32'h10, 32'h20, 32'h0, 3'd2);
    @(negedge clk);
    checkOut("R7 b2b return");
    issue(2'd2, 2'd2, 1'b0, 1'b0, 32'h500, 32'h4, 32'h0, 3'd7);
    @(negedge clk);
    checkOut("R8 b2b memory");
    issue(2'd0, 2'd0, 1'b1, 1'b0, 32'h30, 32'h0, 32'hFF, 3'd1);
    @(negedge clk);
    checkOut("R7 b2b return again");
    idle(32'hA5A5_5A5A);
    @(negedge clk);
    checkOut("R9 idle after b2b");
  endtask

  task automatic testIdle();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      idle(32'h1357_9BDF + i);
      @(negedge clk);
      checkOut("R9 idle hold");
    end
  endtask

  initial begin
    testReset();
    testForms();
    testWrap();
    testRetAddr();
    testBackToBack();
    testIdle();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule